// File: doc/BRIEF.md
# Reset Sequencer with Stabilization Counter

This block turns three reset causes into an orderly, two-stage release of a microcontroller. The three causes are a power-on pulse, a low-voltage level and an illegal-address strobe. When any of them arrives, the block drives the external reset pin low and holds the CPU in reset. It then counts oscillator cycles on a 12-bit counter so that the oscillator has time to settle. Once the counter completes a full turn, the pin is let go. Sixty-four cycles after that, the CPU reset is released so that the vector fetch can begin. All sequential logic advances on the falling edge of the oscillator clock. The power-on input acts as an asynchronous reset of the whole block.

A low-voltage condition only counts as a reset cause when both configuration bits (`cfg_lvi_pwrdn`, `cfg_lvi_rstdis`) are 0. While the condition persists, the counter stays at zero. The stabilization count therefore starts only once the supply has recovered. A status register keeps one sticky bit per cause, and a status read clears it. The counter keeps running after release, and each wrap from its top value back to zero produces a one-cycle tick that a watchdog can use as its prescaled clock.

The state machine has three states. HOLD_PIN means the pin is low and the stabilization count is running. HOLD_CPU means the pin is released and the CPU delay is running. RUN is normal operation. The transitions are: HOLD_PIN to HOLD_CPU on counter wrap, HOLD_CPU to RUN when the 64-cycle delay ends, and any state back to HOLD_PIN when a reset cause is present. Power-on places the machine in HOLD_PIN with the counter at zero.

Top module: `rstseq_top`

## Requirements
- R1: While `por` is high and right after it, the block is in HOLD_PIN: `rst_pin_n`=0, `cpu_rst`=1, `stat_por`=1, `stat_lvi`=0, `stat_ill`=0.
- R2: After `por` falls, `rst_pin_n` rises on exactly the 4096th falling clock edge.
- R3: `cpu_rst` falls exactly 64 falling edges after `rst_pin_n` rises, and `cpu_rst` is never 0 while `rst_pin_n` is 0.
- R4: `wdog_tick` is a one-cycle pulse that follows every wrap of the counter from 4095 to 0. One such wrap ends HOLD_PIN, so the tick coincides with the pin release. In RUN the tick repeats every 4096 cycles.
- R5: An `illegal_addr` strobe sampled on an edge sets `stat_ill` and puts the block in HOLD_PIN (pin low) on that edge. `rst_pin_n` rises 4096 edges after the strobe is removed.
- R6: With both configuration bits 0, `lvd`=1 sets `stat_lvi` and forces HOLD_PIN with the counter held at zero for as long as `lvd` stays high. The pin is released 4096 edges after `lvd` falls.
- R7: If `cfg_lvi_pwrdn`=1 or `cfg_lvi_rstdis`=1, then `lvd` causes no reset and does not set `stat_lvi`.
- R8: `stat_rd` sampled on an edge clears all three status bits. A cause present on the same edge still sets its bit.
- R9: The status bits are sticky and accumulate across causes. A power-on sets `stat_por` and clears `stat_lvi` and `stat_ill`.
- R10: A new cause arriving in HOLD_CPU or RUN returns the block to HOLD_PIN and restarts the full 4096-cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; the logic advances on its falling edge |
| por | input | 1 | Power-on pulse, active high, asynchronous |
| lvd | input | 1 | Low-voltage detect level, active high |
| illegal_addr | input | 1 | Illegal-address access strobe |
| cfg_lvi_pwrdn | input | 1 | Configuration: low-voltage detector powered down |
| cfg_lvi_rstdis | input | 1 | Configuration: low-voltage reset disabled |
| stat_rd | input | 1 | Status read; clears the status bits |
| rst_pin_n | output | 1 | External reset pin drive, active low |
| cpu_rst | output | 1 | CPU internal reset, active high |
| stat_por | output | 1 | Sticky flag: last reset included power-on |
| stat_lvi | output | 1 | Sticky flag: low-voltage reset seen |
| stat_ill | output | 1 | Sticky flag: illegal-address reset seen |
| wdog_tick | output | 1 | One-cycle watchdog prescaler tick |

## Verification
The bench measures the pin and CPU release delays in cycles from the moment each cause is removed. A counter that is off by one, or that starts counting while `lvd` is still high, shows up as 4095, 4097 or a shortened hold. It re-triggers a reset during HOLD_CPU. A design that forgot to clear the counter would release the pin far sooner than 4096 cycles. It holds `lvd` high with each configuration bit set on its own, and a gate written as AND instead of OR would reset the chip there. Status tests combine several causes, then a read, then a power-on, which exposes bits that are not sticky, a read that does not clear, and a power-on that leaves stale flags.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        HOLD_PIN = 2'd0,
        HOLD_CPU = 2'd1,
        RUN      = 2'd2
    } rstseq_state_e;

endpackage

// File: rtl/rstseq_source.sv
module rstseq_source (
    input  logic lvd,
    input  logic illegal_addr,
    input  logic cfg_lvi_pwrdn,
    input  logic cfg_lvi_rstdis,
    output logic lvd_rst,
    output logic any_src
);

    // Low-voltage event only counts when neither configuration bit blocks it
    always_comb begin
        lvd_rst = lvd & ~(cfg_lvi_pwrdn | cfg_lvi_rstdis);
        any_src = lvd_rst | illegal_addr;
    end

endmodule

// File: rtl/rstseq_counter.sv
module rstseq_counter #(
    parameter int CNT_W    = 12,
    parameter int CPU_HOLD = 64
) (
    input  logic osc_clk,
    input  logic por,
    input  logic clr,
    output logic at_max,
    output logic at_cpu_last,
    output logic wdog_tick
);

    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CPU_LAST = CNT_W'(CPU_HOLD - 1);

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        at_max      = (cnt_q == CNT_MAX);
        at_cpu_last = (cnt_q == CPU_LAST);
    end

    always_ff @(negedge osc_clk or posedge por) begin
        if (por) begin
            cnt_q     <= '0;
            wdog_tick <= 1'b0;
        end else begin
            wdog_tick <= ~clr & at_max;
            if (clr)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/rstseq_status.sv
module rstseq_status (
    input  logic osc_clk,
    input  logic por,
    input  logic lvd_rst,
    input  logic illegal_addr,
    input  logic stat_rd,
    output logic stat_por,
    output logic stat_lvi,
    output logic stat_ill
);

    always_ff @(negedge osc_clk or posedge por) begin
        if (por) begin
            stat_por <= 1'b1;
            stat_lvi <= 1'b0;
            stat_ill <= 1'b0;
        end else begin
            stat_por <= stat_por & ~stat_rd;
            stat_lvi <= lvd_rst | (stat_lvi & ~stat_rd);
            stat_ill <= illegal_addr | (stat_ill & ~stat_rd);
        end
    end

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
(
    input  logic osc_clk,
    input  logic por,
    input  logic any_src,
    input  logic at_max,
    input  logic at_cpu_last,
    output logic cnt_clr,
    output logic rst_pin_n,
    output logic cpu_rst
);

    rstseq_state_e state_q, state_d;

    // State register
    always_ff @(negedge osc_clk or posedge por) begin
        if (por)
            state_q <= HOLD_PIN;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOLD_PIN: if (!any_src && at_max)      state_d = HOLD_CPU;
            HOLD_CPU: if (any_src)                 state_d = HOLD_PIN;
                      else if (at_cpu_last)        state_d = RUN;
            RUN:      if (any_src)                 state_d = HOLD_PIN;
            default:                               state_d = HOLD_PIN;
        endcase
    end

    // Outputs
    always_comb begin
        rst_pin_n = 1'b0;
        cpu_rst   = 1'b1;
        cnt_clr   = any_src;
        unique case (state_q)
            HOLD_PIN: begin
                rst_pin_n = 1'b0;
                cpu_rst   = 1'b1;
            end
            HOLD_CPU: begin
                rst_pin_n = 1'b1;
                cpu_rst   = 1'b1;
                cnt_clr   = any_src | at_cpu_last;
            end
            RUN: begin
                rst_pin_n = 1'b1;
                cpu_rst   = 1'b0;
            end
            default: begin
                rst_pin_n = 1'b0;
                cpu_rst   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top #(
    parameter int CNT_W    = 12,
    parameter int CPU_HOLD = 64
) (
    input  logic osc_clk,
    input  logic por,
    input  logic lvd,
    input  logic illegal_addr,
    input  logic cfg_lvi_pwrdn,
    input  logic cfg_lvi_rstdis,
    input  logic stat_rd,
    output logic rst_pin_n,
    output logic cpu_rst,
    output logic stat_por,
    output logic stat_lvi,
    output logic stat_ill,
    output logic wdog_tick
);

    logic lvd_rst;
    logic any_src;
    logic cnt_clr;
    logic at_max;
    logic at_cpu_last;

    rstseq_source u_src (
        .lvd            (lvd),
        .illegal_addr   (illegal_addr),
        .cfg_lvi_pwrdn  (cfg_lvi_pwrdn),
        .cfg_lvi_rstdis (cfg_lvi_rstdis),
        .lvd_rst        (lvd_rst),
        .any_src        (any_src)
    );

    rstseq_counter #(
        .CNT_W    (CNT_W),
        .CPU_HOLD (CPU_HOLD)
    ) u_cnt (
        .osc_clk     (osc_clk),
        .por         (por),
        .clr         (cnt_clr),
        .at_max      (at_max),
        .at_cpu_last (at_cpu_last),
        .wdog_tick   (wdog_tick)
    );

    rstseq_fsm u_fsm (
        .osc_clk     (osc_clk),
        .por         (por),
        .any_src     (any_src),
        .at_max      (at_max),
        .at_cpu_last (at_cpu_last),
        .cnt_clr     (cnt_clr),
        .rst_pin_n   (rst_pin_n),
        .cpu_rst     (cpu_rst)
    );

    rstseq_status u_stat (
        .osc_clk      (osc_clk),
        .por          (por),
        .lvd_rst      (lvd_rst),
        .illegal_addr (illegal_addr),
        .stat_rd      (stat_rd),
        .stat_por     (stat_por),
        .stat_lvi     (stat_lvi),
        .stat_ill     (stat_ill)
    );

endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
    parameter int CPU_HOLD = 64
) (
    input logic osc_clk,
    input logic por,
    input logic lvd,
    input logic illegal_addr,
    input logic cfg_lvi_pwrdn,
    input logic cfg_lvi_rstdis,
    input logic stat_rd,
    input logic rst_pin_n,
    input logic cpu_rst,
    input logic stat_por,
    input logic stat_lvi,
    input logic stat_ill,
    input logic wdog_tick
);

    localparam int WIN_W = $clog2(CPU_HOLD) + 2;

    logic [WIN_W-1:0] win_q;

    always_ff @(negedge osc_clk or posedge por) begin
        if (por)
            win_q <= '0;
        else if (rst_pin_n && cpu_rst)
            win_q <= win_q + 1'b1;
        else
            win_q <= '0;
    end

    // R3
    cpu_order_chk: assert property (@(negedge osc_clk) disable iff (por)
        !rst_pin_n |-> cpu_rst);

    // R3
    cpu_window_chk: assert property (@(negedge osc_clk) disable iff (por)
        win_q <= WIN_W'(CPU_HOLD));

    // R5
    ill_reset_chk: assert property (@(negedge osc_clk) disable iff (por)
        illegal_addr |=> (!rst_pin_n && stat_ill));

    // R6
    lvd_reset_chk: assert property (@(negedge osc_clk) disable iff (por)
        (lvd && !cfg_lvi_pwrdn && !cfg_lvi_rstdis) |=> (!rst_pin_n && stat_lvi));

    // R7
    lvd_masked_chk: assert property (@(negedge osc_clk) disable iff (por)
        (lvd && (cfg_lvi_pwrdn || cfg_lvi_rstdis) && !illegal_addr && rst_pin_n && !stat_lvi)
        |=> !stat_lvi);

    // R4
    tick_pulse_chk: assert property (@(negedge osc_clk) disable iff (por)
        wdog_tick |=> !wdog_tick);

    // R8
    read_clear_chk: assert property (@(negedge osc_clk) disable iff (por)
        (stat_rd && !illegal_addr && !lvd) |=> (!stat_por && !stat_lvi && !stat_ill));

endmodule

bind rstseq_top rstseq_chk #(.CPU_HOLD(CPU_HOLD)) u_chk (
    .osc_clk        (osc_clk),
    .por            (por),
    .lvd            (lvd),
    .illegal_addr   (illegal_addr),
    .cfg_lvi_pwrdn  (cfg_lvi_pwrdn),
    .cfg_lvi_rstdis (cfg_lvi_rstdis),
    .stat_rd        (stat_rd),
    .rst_pin_n      (rst_pin_n),
    .cpu_rst        (cpu_rst),
    .stat_por       (stat_por),
    .stat_lvi       (stat_lvi),
    .stat_ill       (stat_ill),
    .wdog_tick      (wdog_tick)
);

// File: tb/sim_rstseq_top.sv
`timescale 1ns/1ps
module sim_rstseq_top;

    logic osc_clk = 1'b0;
    logic por = 1'b1;
    logic lvd = 1'b0;
    logic illegal_addr = 1'b0;
    logic cfg_lvi_pwrdn = 1'b0;
    logic cfg_lvi_rstdis = 1'b0;
    logic stat_rd = 1'b0;
    logic rst_pin_n, cpu_rst, stat_por, stat_lvi, stat_ill, wdog_tick;

    int checks = 0;
    int errors = 0;

    always #5 osc_clk = ~osc_clk;

    rstseq_top u0 (
        .osc_clk        (osc_clk),
        .por            (por),
        .lvd            (lvd),
        .illegal_addr   (illegal_addr),
        .cfg_lvi_pwrdn  (cfg_lvi_pwrdn),
        .cfg_lvi_rstdis (cfg_lvi_rstdis),
        .stat_rd        (stat_rd),
        .rst_pin_n      (rst_pin_n),
        .cpu_rst        (cpu_rst),
        .stat_por       (stat_por),
        .stat_lvi       (stat_lvi),
        .stat_ill       (stat_ill),
        .wdog_tick      (wdog_tick)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge osc_clk);
    endtask

    // cycles from now until the pin is released
    task automatic time_pin(output int n);
        n = 0;
        while (rst_pin_n == 1'b0 && n < 10000) begin
            @(posedge osc_clk);
            n++;
        end
    endtask

    task automatic time_cpu(output int n);
        n = 0;
        while (cpu_rst == 1'b1 && n < 10000) begin
            @(posedge osc_clk);
            n++;
        end
    endtask

    task automatic release_check(input string req);
        int n;
        time_pin(n);
        check_eq(req, "pin hold cycles", n, 4096);
        check_eq("R4", "tick at pin release", int'(wdog_tick), 1);
        time_cpu(n);
        check_eq("R3", "cpu delay after pin", n, 64);
    endtask

    task automatic pulse_ill();
        @(posedge osc_clk);
        illegal_addr = 1'b1;
        @(posedge osc_clk);
        illegal_addr = 1'b0;
    endtask

    task automatic t_reset_state();
        cyc(3);
        check_eq("R1", "pin in por", int'(rst_pin_n), 0);
        check_eq("R1", "cpu in por", int'(cpu_rst), 1);
        check_eq("R1", "stat bits in por", int'({stat_por, stat_lvi, stat_ill}), 3'b100);
        @(posedge osc_clk);
        por = 1'b0;
        check_eq("R1", "pin right after por", int'(rst_pin_n), 0);
        release_check("R2");
    endtask

    task automatic t_wdog();
        int n;
        n = 0;
        while (wdog_tick == 1'b0 && n < 10000) begin
            @(posedge osc_clk);
            n++;
        end
        check_eq("R4", "first run tick period", n, 4096);
        @(posedge osc_clk);
        check_eq("R4", "tick width", int'(wdog_tick), 0);
        n = 1;
        while (wdog_tick == 1'b0 && n < 10000) begin
            @(posedge osc_clk);
            n++;
        end
        check_eq("R4", "second run tick period", n, 4096);
    endtask

    task automatic t_illegal();
        pulse_ill();
        check_eq("R5", "pin low after strobe", int'(rst_pin_n), 0);
        check_eq("R5", "stat_ill set", int'(stat_ill), 1);
        release_check("R5");
    endtask

    task automatic t_read_clear();
        @(posedge osc_clk);
        stat_rd = 1'b1;
        @(posedge osc_clk);
        stat_rd = 1'b0;
        check_eq("R8", "status after read", int'({stat_por, stat_lvi, stat_ill}), 0);
        // read and strobe on the same edge: set wins
        @(posedge osc_clk);
        stat_rd = 1'b1;
        illegal_addr = 1'b1;
        @(posedge osc_clk);
        stat_rd = 1'b0;
        illegal_addr = 1'b0;
        check_eq("R8", "set beats read", int'({stat_por, stat_lvi, stat_ill}), 3'b001);
        release_check("R5");
        @(posedge osc_clk);
        stat_rd = 1'b1;
        @(posedge osc_clk);
        stat_rd = 1'b0;
    endtask

    task automatic t_lvd();
        @(posedge osc_clk);
        lvd = 1'b1;
        cyc(200);
        check_eq("R6", "pin held during lvd", int'(rst_pin_n), 0);
        check_eq("R6", "stat_lvi set", int'(stat_lvi), 1);
        lvd = 1'b0;
        release_check("R6");
    endtask

    task automatic t_cfg_mask();
        @(posedge osc_clk);
        stat_rd = 1'b1;
        @(posedge osc_clk);
        stat_rd = 1'b0;
        cfg_lvi_pwrdn = 1'b1;
        lvd = 1'b1;
        cyc(50);
        check_eq("R7", "pin with pwrdn", int'(rst_pin_n), 1);
        check_eq("R7", "cpu with pwrdn", int'(cpu_rst), 0);
        check_eq("R7", "stat_lvi with pwrdn", int'(stat_lvi), 0);
        cfg_lvi_pwrdn = 1'b0;
        cfg_lvi_rstdis = 1'b1;
        cyc(50);
        check_eq("R7", "pin with rstdis", int'(rst_pin_n), 1);
        check_eq("R7", "cpu with rstdis", int'(cpu_rst), 0);
        check_eq("R7", "stat_lvi with rstdis", int'(stat_lvi), 0);
        lvd = 1'b0;
        @(posedge osc_clk);
        cfg_lvi_rstdis = 1'b0;
    endtask

    task automatic t_retrigger();
        int n;
        pulse_ill();
        time_pin(n);
        check_eq("R5", "pin hold before retrigger", n, 4096);
        cyc(10);
        check_eq("R10", "in HOLD_CPU", int'({rst_pin_n, cpu_rst}), 2'b11);
        pulse_ill();
        check_eq("R10", "pin low after retrigger", int'(rst_pin_n), 0);
        release_check("R10");
        cyc(100);
        pulse_ill();
        check_eq("R10", "pin low from RUN", int'(rst_pin_n), 0);
        release_check("R10");
    endtask

    task automatic t_sticky_por();
        @(posedge osc_clk);
        lvd = 1'b1;
        @(posedge osc_clk);
        lvd = 1'b0;
        pulse_ill();
        check_eq("R9", "lvi and ill both sticky", int'({stat_lvi, stat_ill}), 2'b11);
        @(posedge osc_clk);
        por = 1'b1;
        @(posedge osc_clk);
        check_eq("R9", "por clears others", int'({stat_por, stat_lvi, stat_ill}), 3'b100);
        por = 1'b0;
        release_check("R2");
    endtask

    initial begin
        t_reset_state();
        t_wdog();
        t_illegal();
        t_read_clear();
        t_lvd();
        t_cfg_mask();
        t_retrigger();
        t_sticky_por();
        cyc(5);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge osc_clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule